// File: doc/BRIEF.md
# Key-Protected Pin Multiplex Matrix

This block decides what each of eighteen external pins does. Every pin has a 32-bit configuration word on a small register bus. The word chooses one of eight internal function pairs, or a software-driven (PIO) mode, or no function at all. It also holds separate polarity inversions for the outgoing and incoming signal. The block drives a registered pad output and a registered pad output enable for each pin. It also returns the pin inputs to the internal functions, again through a register.

The lower eight pins fall back to PIO mode after reset. The upper ten pins are multiplex-only: they have no PIO mode. Their idle code leaves the pad to its primary owner, which is outside this block.

The routing fields (function select and both inversions) are guarded by a key handshake. Software reads a key register and then writes the same value straight back. That arms exactly one configuration write. The key comes from a 16-bit LFSR that steps on every successful unlock, so an old key cannot be replayed. The PIO level and enable bits are never guarded.

Top module: `pinmux_matrix`

## Requirements
- R1: After reset, every configuration word reads 0x3F in its select field and zero in bits 9, 10, 16 and 17. Every pad_oe is 0, the mode status word at 0x64 reads 0x000FF, and the key register at 0x70 reads 0xACE1.
- R2: The configuration word for pin n sits at byte address 4·n. A write made without an armed unlock leaves select [5:0], output invert (bit 9) and input invert (bit 10) unchanged. The same write still updates PIO enable (bit 16) and PIO level (bit 17) on pins 0–7.
- R3: A read of the key register, followed directly by a write of that same value to it, arms the next bus write. If that next write targets a configuration word, its protected fields update. The arm is then gone, so a second write is locked again.
- R4: The arm is not set, or is cleared, in two cases: the written key differs from the one read, or any other write occurs between the arming and the configuration write.
- R5: The key register holds a 16-bit LFSR seeded with 0xACE1. It changes only on a successful unlock. The new value is the old value shifted left by one, with bit 0 set to the XOR of old bits 15, 13, 12 and 10.
- R6: On pins 0–7 with select 0x3F (PIO mode), pad_oe equals bit 16 and pad_out equals bit 17 XOR the output-invert bit.
- R7: With select code s in 0..7, pad_out equals func_out[s] XOR the output-invert bit, and pad_oe equals func_oe[s]. Select codes 0x08..0x3E drive pad_oe = 0 and pad_out = 0.
- R8: On pins 8–17, bits 16 and 17 are ignored and read as zero. Select 0x3F drives pad_oe = 0.
- R9: func_in[f] equals pad_in[p] XOR the input-invert bit of p, where p is the lowest-numbered pin whose select equals f. func_in[f] is 0 when no pin selects f. The value appears one clock after pad_in.
- R10: In the mode status word at 0x64, bit p is set for pins 0–7 when select is 0x3F. For pins 8–17, bit p is set when select is not 0x3F.
- R11: Bit 18 of a configuration word shows the pad input sampled one clock earlier. All other unlisted bits read zero, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the following cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 18 | Pad input levels |
| pad_out | output | 18 | Registered pad output levels |
| pad_oe | output | 18 | Registered pad output enables |
| func_out | input | 8 | Output value of each internal function |
| func_oe | input | 8 | Output enable of each internal function |
| func_in | output | 8 | Registered input value delivered to each internal function |

## Verification
A wrong lock state shows up on the second readback after an unlock: the protected field either refuses the first write or accepts a later one. The key value read afterwards also exposes a missed or extra LFSR step at the next key read. A corrupted select or inversion register appears on pad_out or pad_oe one clock after the configuration write, and on func_in one clock after a pad_in change. Bad priority among pins that share a function can be seen by deselecting the lower pin and watching func_in switch to the higher one.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int SEL_W = 6;
  localparam logic [SEL_W-1:0] SEL_IDLE = 6'h3F;
  typedef logic [SEL_W-1:0] sel_t;

  // field positions inside a configuration word
  localparam int BIT_OINV   = 9;
  localparam int BIT_IINV   = 10;
  localparam int BIT_PIOE   = 16;
  localparam int BIT_PIOLVL = 17;
  localparam int BIT_INSTAT = 18;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_SEED = 16'hACE1;

  function automatic logic [KEY_W-1:0] key_next(input logic [KEY_W-1:0] k);
    return {k[KEY_W-2:0], k[15] ^ k[13] ^ k[12] ^ k[10]};
  endfunction
endpackage

// File: rtl/pinmux_keylock.sv
module pinmux_keylock
  import pinmux_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_rd,
  input  logic              other_rd,
  input  logic              key_wr,
  input  logic              any_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  key_q,
  output logic              arm_q
);
  logic rd_seen_q;
  logic match;

  assign match = key_wr && rd_seen_q && (wdata == DATA_W'(key_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= KEY_SEED;
      rd_seen_q <= 1'b0;
      arm_q     <= 1'b0;
    end else if (any_wr) begin
      rd_seen_q <= 1'b0;
      arm_q     <= match;
      if (match) key_q <= key_next(key_q);
    end else if (key_rd) begin
      rd_seen_q <= 1'b1;
    end else if (other_rd) begin
      rd_seen_q <= 1'b0;
    end
  end

  // R3
  arm_single_use_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_q && any_wr) |=> !arm_q);

  // R4
  arm_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    (any_wr && !(key_wr && rd_seen_q)) |=> !arm_q);

  // R5
  key_step_on_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_q) |-> arm_q);
endmodule

// File: rtl/pinmux_cfg_bank.sv
module pinmux_cfg_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 18,
  parameter int NUM_PIO  = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           unlock,
  input  sel_t                           wr_sel,
  input  logic                           wr_oinv,
  input  logic                           wr_iinv,
  input  logic                           wr_pioe,
  input  logic                           wr_piolvl,
  output logic [NUM_PINS-1:0][SEL_W-1:0] sel_q,
  output logic [NUM_PINS-1:0]            oinv_q,
  output logic [NUM_PINS-1:0]            iinv_q,
  output logic [NUM_PINS-1:0]            pioe_q,
  output logic [NUM_PINS-1:0]            piolvl_q
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[p]  <= SEL_IDLE;
        oinv_q[p] <= 1'b0;
        iinv_q[p] <= 1'b0;
      end else if (hit && unlock) begin
        sel_q[p]  <= wr_sel;
        oinv_q[p] <= wr_oinv;
        iinv_q[p] <= wr_iinv;
      end
    end

    if (p < NUM_PIO) begin : g_pio
      always_ff @(posedge clk) begin
        if (rst) begin
          pioe_q[p]   <= 1'b0;
          piolvl_q[p] <= 1'b0;
        end else if (hit) begin
          pioe_q[p]   <= wr_pioe;
          piolvl_q[p] <= wr_piolvl;
        end
      end
    end else begin : g_nopio
      assign pioe_q[p]   = 1'b0;
      assign piolvl_q[p] = 1'b0;
    end
  end

  // R2
  locked_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlock) |=> ($stable(sel_q) && $stable(oinv_q) && $stable(iinv_q)));
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS  = 18,
  parameter int NUM_PIO   = 8,
  parameter int NUM_FUNCS = 8,
  localparam int FSEL_W   = $clog2(NUM_FUNCS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PINS-1:0][SEL_W-1:0] sel_q,
  input  logic [NUM_PINS-1:0]            oinv_q,
  input  logic [NUM_PINS-1:0]            iinv_q,
  input  logic [NUM_PINS-1:0]            pioe_q,
  input  logic [NUM_PINS-1:0]            piolvl_q,
  input  logic [NUM_PINS-1:0]            pad_in,
  input  logic [NUM_FUNCS-1:0]           func_out,
  input  logic [NUM_FUNCS-1:0]           func_oe,
  output logic [NUM_PINS-1:0]            pad_out_q,
  output logic [NUM_PINS-1:0]            pad_oe_q,
  output logic [NUM_FUNCS-1:0]           func_in_q
);
  logic [NUM_PINS-1:0]  drv_out, drv_oe;
  logic [NUM_FUNCS-1:0] fin, taken;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic o, e;
    always_comb begin
      o = 1'b0;
      e = 1'b0;
      if (sel_q[p] == SEL_IDLE) begin
        if (p < NUM_PIO) begin
          o = piolvl_q[p] ^ oinv_q[p];
          e = pioe_q[p];
        end
      end else if (sel_q[p] < SEL_W'(NUM_FUNCS)) begin
        o = func_out[sel_q[p][FSEL_W-1:0]] ^ oinv_q[p];
        e = func_oe[sel_q[p][FSEL_W-1:0]];
      end
    end
    assign drv_out[p] = o;
    assign drv_oe[p]  = e;
  end

  // highest pin first so the lowest matching pin is written last and wins
  always_comb begin
    fin   = '0;
    taken = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      for (int f = 0; f < NUM_FUNCS; f++) begin
        if (sel_q[p] == SEL_W'(f)) begin
          fin[f]   = pad_in[p] ^ iinv_q[p];
          taken[f] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_q <= '0;
      pad_oe_q  <= '0;
      func_in_q <= '0;
    end else begin
      pad_out_q <= drv_out;
      pad_oe_q  <= drv_oe;
      func_in_q <= fin;
    end
  end

  logic [NUM_PINS-1:0] mux_only_idle;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assign mux_only_idle[p] = (p >= NUM_PIO) && (sel_q[p] == SEL_IDLE);
  end

  // R8
  mux_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe_q & $past(mux_only_idle)) == '0));

  // R9
  orphan_input_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((func_in_q & ~$past(taken)) == '0));
endmodule

// File: rtl/pinmux_matrix.sv
module pinmux_matrix
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS    = 18,
  parameter int NUM_PIO     = 8,
  parameter int NUM_FUNCS   = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int STATUS_ADDR = 'h64,
  parameter int KEY_ADDR    = 'h70
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-1:0]  pad_out,
  output logic [NUM_PINS-1:0]  pad_oe,
  input  logic [NUM_FUNCS-1:0] func_out,
  input  logic [NUM_FUNCS-1:0] func_oe,
  output logic [NUM_FUNCS-1:0] func_in
);
  localparam int IDX_W  = $clog2(NUM_PINS);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] word_idx;
  logic              cfg_hit, key_hit, stat_hit;
  logic [NUM_PINS-1:0][SEL_W-1:0] sel_q;
  logic [NUM_PINS-1:0] oinv_q, iinv_q, pioe_q, piolvl_q, pad_in_q, mode;
  logic [KEY_W-1:0]    key_q;
  logic                arm_q;
  logic [DATA_W-1:0]   rd_word;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign cfg_hit  = (bus_addr[1:0] == 2'b00) && (word_idx < WIDX_W'(NUM_PINS));
  assign key_hit  = (bus_addr == ADDR_W'(KEY_ADDR));
  assign stat_hit = (bus_addr == ADDR_W'(STATUS_ADDR));

  pinmux_keylock #(.DATA_W(DATA_W)) u_key (
    .clk      (clk),
    .rst      (rst),
    .key_rd   (bus_rd && key_hit),
    .other_rd (bus_rd && !key_hit),
    .key_wr   (bus_wr && key_hit),
    .any_wr   (bus_wr),
    .wdata    (bus_wdata),
    .key_q    (key_q),
    .arm_q    (arm_q)
  );

  pinmux_cfg_bank #(.NUM_PINS(NUM_PINS), .NUM_PIO(NUM_PIO)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && cfg_hit),
    .wr_idx    (word_idx[IDX_W-1:0]),
    .unlock    (arm_q),
    .wr_sel    (bus_wdata[SEL_W-1:0]),
    .wr_oinv   (bus_wdata[BIT_OINV]),
    .wr_iinv   (bus_wdata[BIT_IINV]),
    .wr_pioe   (bus_wdata[BIT_PIOE]),
    .wr_piolvl (bus_wdata[BIT_PIOLVL]),
    .sel_q     (sel_q),
    .oinv_q    (oinv_q),
    .iinv_q    (iinv_q),
    .pioe_q    (pioe_q),
    .piolvl_q  (piolvl_q)
  );

  pinmux_route #(.NUM_PINS(NUM_PINS), .NUM_PIO(NUM_PIO), .NUM_FUNCS(NUM_FUNCS)) u_route (
    .clk       (clk),
    .rst       (rst),
    .sel_q     (sel_q),
    .oinv_q    (oinv_q),
    .iinv_q    (iinv_q),
    .pioe_q    (pioe_q),
    .piolvl_q  (piolvl_q),
    .pad_in    (pad_in),
    .func_out  (func_out),
    .func_oe   (func_oe),
    .pad_out_q (pad_out),
    .pad_oe_q  (pad_oe),
    .func_in_q (func_in)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    if (p < NUM_PIO) begin : g_pio
      assign mode[p] = (sel_q[p] == SEL_IDLE);
    end else begin : g_mux
      assign mode[p] = (sel_q[p] != SEL_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pad_in_q <= '0;
    else     pad_in_q <= pad_in;
  end

  always_comb begin
    logic [IDX_W-1:0] ri;
    ri      = word_idx[IDX_W-1:0];
    rd_word = '0;
    if (cfg_hit) begin
      rd_word[SEL_W-1:0]  = sel_q[ri];
      rd_word[BIT_OINV]   = oinv_q[ri];
      rd_word[BIT_IINV]   = iinv_q[ri];
      rd_word[BIT_PIOE]   = pioe_q[ri];
      rd_word[BIT_PIOLVL] = piolvl_q[ri];
      rd_word[BIT_INSTAT] = pad_in_q[ri];
    end else if (stat_hit) begin
      rd_word = DATA_W'(mode);
    end else if (key_hit) begin
      rd_word = DATA_W'(key_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !cfg_hit && !stat_hit && !key_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_pinmux_matrix.sv
`timescale 1ns/1ps
module tb_pinmux_matrix;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [17:0] pad_in = '0;
  logic [17:0] pad_out, pad_oe;
  logic [7:0]  func_out = '0, func_oe = '0;
  logic [7:0]  func_in;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] exp_key = 16'hACE1;

  always #2.5 clk = ~clk;

  pinmux_matrix dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .func_out(func_out), .func_oe(func_oe), .func_in(func_in)
  );

  function automatic logic [15:0] lfsr_step(input logic [15:0] k);
    return {k[14:0], k[15] ^ k[13] ^ k[12] ^ k[10]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    logic [31:0] k;
    rd(8'h70, k);
    chk("R5 key value", k, {16'h0, exp_key});
    wr(8'h70, k);
    exp_key = lfsr_step(exp_key);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d);  chk("R1 pin0 word", d, 32'h3F);
    rd(8'h30, d);  chk("R1 pin12 word", d, 32'h3F);
    rd(8'h64, d);  chk("R1 mode status", d, 32'h000FF);
    rd(8'h70, d);  chk("R1 R5 key seed", d, 32'hACE1);
    chk("R1 pad_oe", {14'h0, pad_oe}, 32'h0);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    wr(8'h00, 32'h0003_0605);
    rd(8'h00, d);  chk("R2 locked write", d, 32'h0003_003F);
    settle();
    chk("R6 pio out", {31'h0, pad_out[0]}, 32'h1);
    chk("R6 pio oe", {31'h0, pad_oe[0]}, 32'h1);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    unlock();
    wr(8'h00, 32'h0000_0202);
    rd(8'h00, d);  chk("R3 unlocked write", d, 32'h202);
    rd(8'h70, d);  chk("R5 key advanced", d, {16'h0, exp_key});
    wr(8'h00, 32'h0000_0003);
    rd(8'h00, d);  chk("R3 one shot", d, 32'h202);
  endtask

  task automatic t_func_out();
    func_oe = 8'h04; func_out = 8'h04;
    settle();
    chk("R7 func out inverted", {31'h0, pad_out[0]}, 32'h0);
    chk("R7 func oe", {31'h0, pad_oe[0]}, 32'h1);
    func_out = 8'h00;
    settle();
    chk("R7 func out low inverted", {31'h0, pad_out[0]}, 32'h1);
  endtask

  task automatic t_wrong_key();
    logic [31:0] d;
    rd(8'h70, d);
    wr(8'h70, d ^ 32'h1);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, d);  chk("R4 wrong key", d, 32'h3F);
    unlock();
    wr(8'h64, 32'h0);
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, d);  chk("R4 intervening write", d, 32'h3F);
  endtask

  task automatic t_bad_code();
    logic [31:0] d;
    unlock();
    wr(8'h04, 32'h0000_0020);
    func_oe = 8'hFF; func_out = 8'hFF;
    settle();
    chk("R7 code 0x20 oe", {31'h0, pad_oe[1]}, 32'h0);
    chk("R7 code 0x20 out", {31'h0, pad_out[1]}, 32'h0);
    rd(8'h04, d);  chk("R7 code readback", d, 32'h20);
  endtask

  task automatic t_mux_only();
    logic [31:0] d;
    wr(8'h24, 32'h0003_0000);
    rd(8'h24, d);  chk("R8 pio bits ignored", d, 32'h3F);
    settle();
    chk("R8 idle oe", {31'h0, pad_oe[9]}, 32'h0);
    unlock();
    wr(8'h24, 32'h0000_0005);
    settle();
    chk("R7 pin9 oe", {31'h0, pad_oe[9]}, 32'h1);
    chk("R7 pin9 out", {31'h0, pad_out[9]}, 32'h1);
  endtask

  task automatic t_input_route();
    unlock();
    wr(8'h30, 32'h0000_0405);
    pad_in = '0; pad_in[9] = 1'b1; pad_in[0] = 1'b1;
    settle();
    chk("R9 lowest pin wins", {24'h0, func_in}, 32'h24);
    unlock();
    wr(8'h24, 32'h0000_003F);
    settle();
    chk("R9 fallback inverted", {24'h0, func_in}, 32'h24);
    pad_in[12] = 1'b1;
    settle();
    chk("R9 inverted high", {24'h0, func_in}, 32'h04);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pad_in[3] = 1'b1;
    settle();
    rd(8'h0C, d);  chk("R11 input bit", d, 32'h0004_003F);
    rd(8'h48, d);  chk("R11 unmapped", d, 32'h0);
    rd(8'h64, d);  chk("R10 mode status", d, 32'h0000_10FC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_func_out();
    t_wrong_key();
    t_bad_code();
    t_mux_only();
    t_input_route();
    t_status();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule